// File: doc/BRIEF.md
# Windowed Sub-Block Recursion Scheduler

This block is the sequencer for one serial soft-in soft-out trellis decoder that owns a single sub-block of a code block. The sub-block is cut into `NWIN` windows of `WLS` trellis steps each, so its length is always an exact multiple of the window length. The windows are processed one after the other. For every cycle the block produces the trellis position handled by the forward engine, by the backward engine and by the acquisition engine. It also produces the start-metric select for each backward pass, a strobe marking valid soft-output values, and the read and write controls of a small store that holds state metrics at window borders.

Each pass over the sub-block takes `NWIN+1` phases of `WLS` cycles. In phase `p`, the forward engine walks window `p` upwards. In the same phase, the backward engine walks window `p-1` downwards and soft outputs are emitted alongside it. While window `p` is being walked forwards, the acquisition engine estimates its backward start metrics: it runs `AL` steps downwards over the positions just beyond that window's end and finishes on the last cycle of the phase. The mode input can replace acquisition with metrics saved at the window borders during the previous pass. In that mode the acquisition engine stays idle, and the first pass starts from all-equal metrics. The last window of a terminated block always starts from the known end state.

Top module: `win_map_sched`

## Requirements
- R1: After reset, and whenever the block is idle, `busy`, `done` and every valid, start, read and write strobe are 0, and `bwd_init_sel` is 0.
- R2: A start accepted at a clock edge makes the next cycle the first cycle of pass 0. In phase p (0..NWIN-1), cycle c (0..WLS-1), `fwd_vld`=1 and `fwd_idx`=p*WLS+c. `fwd_first` is 1 only at p=0, c=0. In phase NWIN, `fwd_vld`=0.
- R3: In phase p (1..NWIN), cycle c, `bwd_vld`=`llr_vld`=1 and `bwd_idx`=(p-1)*WLS+WLS-1-c, which is at most one soft output per cycle. `bwd_start` is 1 only at c=0. In phase 0, `bwd_vld` and `llr_vld` are 0.
- R4: In acquisition mode (`nii_mode`=0 at start), during phase p<NWIN, `acq_vld` is 1 exactly in the last AL cycles (c >= WLS-AL, with AL <= WLS), with `acq_idx`=(p+1)*WLS+WLS-1-c. It therefore ends at (p+1)*WLS on the phase's last cycle.
- R5: While `bwd_vld`=1, `bwd_init_sel` uses this encoding: 0 = acquired metrics, 1 = stored border metrics, 2 = all-equal metrics, 3 = terminated state.
- R6: When `last_sub`=1 at start, the final window (p=NWIN) uses `bwd_init_sel`=3. No acquisition runs in phase NWIN-1, and no border read is issued for that window.
- R7: In border-reuse mode (`nii_mode`=1 at start), `acq_vld` stays 0. In pass 0, `bwd_init_sel`=2. In later passes, `bwd_init_sel`=1, and `bnd_rd`=1 with `bnd_rd_addr`=p at `bwd_start` of phase p, except in the terminated case of R6.
- R8: In border-reuse mode, `bnd_wr`=1 with `bnd_wr_addr`=p-1 on the last cycle (c=WLS-1) of every backward phase p, in every pass. `bnd_wr` is 0 in acquisition mode.
- R9: The schedule repeats for `n_iter` passes, with a value of 0 taken as 1. `done` is a one-cycle pulse in the cycle after the last soft output of the last pass. In that cycle `busy` is 0, and a new start is accepted.
- R10: `start` is ignored while `busy`=1. `nii_mode`, `last_sub` and `n_iter` are sampled only at an accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a decode of the sub-block when idle |
| nii_mode | input | 1 | 1 = reuse stored border metrics, 0 = acquisition |
| last_sub | input | 1 | Sub-block ends the code block (terminated) |
| n_iter | input | ITW | Number of passes (0 means 1) |
| busy | output | 1 | Schedule in progress |
| done | output | 1 | One-cycle pulse after the last soft output |
| fwd_vld | output | 1 | Forward step valid |
| fwd_first | output | 1 | First forward step of the sub-block |
| fwd_idx | output | IXW | Forward trellis position |
| bwd_vld | output | 1 | Backward step valid |
| bwd_start | output | 1 | First backward step of a window |
| bwd_idx | output | IXW | Backward trellis position |
| llr_vld | output | 1 | Soft output valid at `bwd_idx` |
| bwd_init_sel | output | 2 | Backward start-metric source |
| acq_vld | output | 1 | Acquisition step valid |
| acq_idx | output | IXW | Acquisition trellis position |
| bnd_rd | output | 1 | Read stored border metrics |
| bnd_rd_addr | output | WIW | Border slot to read |
| bnd_wr | output | 1 | Write border metrics |
| bnd_wr_addr | output | WIW | Border slot to write |

## Verification
The bench goes after the window seams, where an off-by-one in the phase lag would send forward and backward positions into the same window or leave a one-cycle gap in soft output. It checks the acquisition start cycle: a wrong threshold would run more or fewer than AL steps, or would not end at the window border. It also checks the terminated final window, where a design that forgot the special case would acquire past the block end or read a border slot that is never written. Finally, it covers the pass boundaries in border-reuse mode, where a design could keep the all-equal select after pass 0. The bench also pulses `start` while busy, with changed mode inputs, issues a start in the `done` cycle, and requests zero passes. A design that restarted, re-sampled the inputs or dropped the back-to-back start would then diverge from the model.

// File: rtl/win_map_sched.sv
module win_map_sched #(
  parameter int WLS  = 128,
  parameter int NWIN = 4,
  parameter int AL   = 128,
  parameter int ITW  = 4,
  localparam int SBL = NWIN * WLS,
  localparam int IXW = $clog2(SBL + WLS + 1),
  localparam int WIW = $clog2(NWIN + 2),
  localparam int CW  = $clog2(WLS)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic           nii_mode,
  input  logic           last_sub,
  input  logic [ITW-1:0] n_iter,
  output logic           busy,
  output logic           done,
  output logic           fwd_vld,
  output logic           fwd_first,
  output logic [IXW-1:0] fwd_idx,
  output logic           bwd_vld,
  output logic           bwd_start,
  output logic [IXW-1:0] bwd_idx,
  output logic           llr_vld,
  output logic [1:0]     bwd_init_sel,
  output logic           acq_vld,
  output logic [IXW-1:0] acq_idx,
  output logic           bnd_rd,
  output logic [WIW-1:0] bnd_rd_addr,
  output logic           bnd_wr,
  output logic [WIW-1:0] bnd_wr_addr
);
  localparam logic [1:0] SEL_ACQ = 2'd0, SEL_MEM = 2'd1, SEL_FLAT = 2'd2, SEL_TERM = 2'd3;

  logic           busy_q, done_q, nii_q, last_q;
  logic [ITW-1:0] iters_q, pass_q;
  logic [WIW-1:0] phase_q, wb;
  logic [CW-1:0]  cyc_q;
  logic           cyc_end, term_win, acq_win;

  assign cyc_end = (cyc_q == CW'(WLS - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
      nii_q   <= 1'b0;
      last_q  <= 1'b0;
      iters_q <= '0;
      pass_q  <= '0;
      phase_q <= '0;
      cyc_q   <= '0;
    end else begin
      done_q <= 1'b0;
      if (!busy_q) begin
        if (start) begin
          busy_q  <= 1'b1;
          nii_q   <= nii_mode;
          last_q  <= last_sub;
          iters_q <= (n_iter == '0) ? ITW'(1) : n_iter;
          pass_q  <= '0;
          phase_q <= '0;
          cyc_q   <= '0;
        end
      end else if (!cyc_end) begin
        cyc_q <= cyc_q + 1'b1;
      end else begin
        cyc_q <= '0;
        if (phase_q != WIW'(NWIN)) begin
          phase_q <= phase_q + 1'b1;
        end else begin
          phase_q <= '0;
          if (pass_q == iters_q - 1'b1) begin
            busy_q <= 1'b0;
            done_q <= 1'b1;
          end else begin
            pass_q <= pass_q + 1'b1;
          end
        end
      end
    end
  end

  assign busy = busy_q;
  assign done = done_q;
  assign wb   = phase_q - 1'b1;

  assign fwd_vld   = busy_q && (phase_q < WIW'(NWIN));
  assign fwd_first = fwd_vld && (phase_q == '0) && (cyc_q == '0);
  assign fwd_idx   = IXW'(phase_q) * IXW'(WLS) + IXW'(cyc_q);

  assign bwd_vld   = busy_q && (phase_q != '0);
  assign bwd_start = bwd_vld && (cyc_q == '0);
  assign llr_vld   = bwd_vld;
  assign bwd_idx   = IXW'(wb) * IXW'(WLS) + IXW'(WLS - 1) - IXW'(cyc_q);
  assign term_win  = last_q && (wb == WIW'(NWIN - 1));

  always_comb begin
    bwd_init_sel = SEL_ACQ;
    if (bwd_vld) begin
      if (term_win)             bwd_init_sel = SEL_TERM;
      else if (nii_q)           bwd_init_sel = (pass_q == '0) ? SEL_FLAT : SEL_MEM;
    end
  end

  assign acq_win = (32'(cyc_q) + AL) >= WLS;
  assign acq_vld = fwd_vld && !nii_q && acq_win &&
                   !(last_q && (phase_q == WIW'(NWIN - 1)));
  assign acq_idx = (IXW'(phase_q) + 1'b1) * IXW'(WLS) + IXW'(WLS - 1) - IXW'(cyc_q);

  assign bnd_rd      = bwd_start && nii_q && (pass_q != '0) && !term_win;
  assign bnd_rd_addr = phase_q;
  assign bnd_wr      = bwd_vld && nii_q && cyc_end;
  assign bnd_wr_addr = wb;
endmodule

module win_map_sched_chk #(
  parameter int IXW = 8
) (
  input logic           clk,
  input logic           rst_n,
  input logic           busy,
  input logic           done,
  input logic           fwd_vld,
  input logic           fwd_first,
  input logic [IXW-1:0] fwd_idx,
  input logic           bwd_vld,
  input logic           bwd_start,
  input logic [IXW-1:0] bwd_idx,
  input logic           llr_vld,
  input logic [1:0]     bwd_init_sel,
  input logic           acq_vld,
  input logic           bnd_rd,
  input logic           bnd_wr
);
  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !(fwd_vld || bwd_vld || llr_vld || acq_vld || bnd_rd || bnd_wr));
  // R2
  fwd_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fwd_vld && !fwd_first && $past(fwd_vld)) |-> (fwd_idx == $past(fwd_idx) + 1'b1));
  // R3
  bwd_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bwd_vld && !bwd_start) |-> (llr_vld && bwd_idx == $past(bwd_idx) - 1'b1));
  // R6
  term_no_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bwd_start && bwd_init_sel == 2'd3) |-> !bnd_rd);
  // R7
  mode_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(bnd_wr && acq_vld));
  // R9
  done_after_llr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(llr_vld) && !busy));
endmodule

bind win_map_sched win_map_sched_chk #(.IXW(IXW)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done),
  .fwd_vld(fwd_vld), .fwd_first(fwd_first), .fwd_idx(fwd_idx),
  .bwd_vld(bwd_vld), .bwd_start(bwd_start), .bwd_idx(bwd_idx),
  .llr_vld(llr_vld), .bwd_init_sel(bwd_init_sel), .acq_vld(acq_vld),
  .bnd_rd(bnd_rd), .bnd_wr(bnd_wr)
);

// File: tb/sim_win_map_sched.sv
`timescale 1ns/1ps
module sim_win_map_sched;
  localparam int W = 8, NW = 3, AL = 5, ITW = 3;
  localparam int IXW = $clog2(NW*W + W + 1), WIW = $clog2(NW + 2);
  localparam int P = (NW + 1) * W;

  logic clk = 0, rst_n = 0, start = 0, nii_mode = 0, last_sub = 0;
  logic [ITW-1:0] n_iter = '0;
  logic busy, done, fwd_vld, fwd_first, bwd_vld, bwd_start, llr_vld, acq_vld, bnd_rd, bnd_wr;
  logic [IXW-1:0] fwd_idx, bwd_idx, acq_idx;
  logic [1:0] bwd_init_sel;
  logic [WIW-1:0] bnd_rd_addr, bnd_wr_addr;

  always #5 clk = ~clk;

  win_map_sched #(.WLS(W), .NWIN(NW), .AL(AL), .ITW(ITW)) u0 (.*);

  int nchk = 0, nfail = 0, ncyc = 0;
  bit m_busy = 0, m_done = 0, m_nii = 0, m_last = 0;
  int m_it = 0, m_t = 0;

  always @(posedge clk) begin
    ncyc++;
    if (ncyc > 100000) begin
      nfail++; nchk++;
      $display("FAIL watchdog: run did not end (actual %0d cycles, expected fewer)", ncyc);
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
    end
  end

  task automatic chk(string tag, int act, int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s at t=%0t: actual %0d expected %0d", tag, $time, act, exp);
    end
  endtask

  task automatic compare();
    int pass, r, ph, c, wb, sel;
    bit fv, bv, av, term, rd, wr;
    pass = 0; ph = 0; c = 0;
    if (m_busy) begin
      pass = m_t / P; r = m_t % P; ph = r / W; c = r % W;
    end
    wb = ph - 1;
    fv = m_busy && ph < NW;
    bv = m_busy && ph >= 1;
    term = bv && m_last && wb == NW - 1;
    av = m_busy && !m_nii && ph < NW && c >= W - AL && !(m_last && ph == NW - 1);
    sel = !bv ? 0 : term ? 3 : m_nii ? (pass == 0 ? 2 : 1) : 0;
    rd = bv && c == 0 && m_nii && pass > 0 && !term;
    wr = bv && m_nii && c == W - 1;
    chk("R1 busy", busy, m_busy);
    chk("R9 done", done, m_done);
    chk("R2 fwd_vld", fwd_vld, fv);
    chk("R2 fwd_first", fwd_first, fv && ph == 0 && c == 0);
    if (fv) chk("R2 fwd_idx", fwd_idx, ph*W + c);
    chk("R3 bwd_vld", bwd_vld, bv);
    chk("R3 llr_vld", llr_vld, bv);
    chk("R3 bwd_start", bwd_start, bv && c == 0);
    if (bv) chk("R3 bwd_idx", bwd_idx, wb*W + W - 1 - c);
    chk("R5 R6 R7 bwd_init_sel", bwd_init_sel, sel);
    chk("R4 R6 R7 acq_vld", acq_vld, av);
    if (av) chk("R4 acq_idx", acq_idx, (ph + 1)*W + W - 1 - c);
    chk("R7 bnd_rd", bnd_rd, rd);
    if (rd) chk("R7 bnd_rd_addr", bnd_rd_addr, ph);
    chk("R8 bnd_wr", bnd_wr, wr);
    if (wr) chk("R8 bnd_wr_addr", bnd_wr_addr, wb);
  endtask

  task automatic step(bit st, bit nm, bit ls, int it);
    compare();
    start = st; nii_mode = nm; last_sub = ls; n_iter = ITW'(it);
    if (m_busy) begin
      if (m_t == m_it * P - 1) begin m_busy = 0; m_done = 1; end
      else begin m_t++; m_done = 0; end
    end else begin
      m_done = 0;
      if (st) begin
        m_busy = 1; m_t = 0; m_nii = nm; m_last = ls;
        m_it = (it == 0) ? 1 : it;
      end
    end
    @(posedge clk);
    @(negedge clk);
  endtask

  // R10: noisy runs pulse start with inverted settings while busy
  task automatic run(bit nm, bit ls, int it, bit noise);
    int k = 0;
    step(1, nm, ls, it);
    while (m_busy) begin
      step(noise && (k % 3 == 1), !nm, !ls, (it + 1) % 8);
      k++;
    end
  endtask

  initial begin
    @(negedge clk); @(negedge clk);
    compare();
    @(negedge clk);
    rst_n = 1;
    step(0, 0, 0, 0);
    run(0, 0, 2, 1);
    run(0, 1, 1, 0);
    run(1, 0, 3, 1);
    run(1, 1, 2, 0);
    run(0, 0, 0, 1);
    run(1, 0, 1, 0);
    step(0, 0, 0, 0);
    step(0, 0, 0, 0);
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule